// File: doc/BRIEF.md
# Power-on reset sequencer

This block makes the single chip-wide reset out of already digitized supply and pin events. A power-on pulse or a qualified brown-out puts the sequencer into hold. When the internal source clears, a power-up delay counted in ticks of a slow low-power clock runs first. A start-up delay counted in core clock cycles, which lets the main oscillator settle, follows it. The core reset drops only when the last enabled stage has finished.

Each stage can be skipped through configuration. The power-up delay is skipped when its disable bit is set. The start-up delay is skipped when the core runs from an external clock. A brown-out is qualified over several slow ticks, and a two-bit mode decides whether it is honoured, with sleep taken into account. An optional active-low reset pin is synchronized and filtered against glitches. The pin is ORed into the reset after the timers, so the timers never wait on it. A two-bit code keeps the most recent reset cause.

Top module: `por_seq_ctrl`

## Requirements
- R1: While `por_pulse_i` is high, `core_rst_o` is 1 from the next clock on, and `cause_o` reads 2'b00 (power-on).
- R2: With `cfg_pwrt_dis_i`=0, the power-up stage needs exactly PWRT_TICKS cycles with `slow_tick_i` high before it can end. With `cfg_pwrt_dis_i`=1 the stage is skipped.
- R3: With `cfg_ext_clk_i`=0, the start-up stage follows the power-up stage and lasts exactly OST_CYCLES core clocks. `core_rst_o` drops on the clock that completes it. With `cfg_ext_clk_i`=1 the stage is skipped.
- R4: With `cfg_pwrt_dis_i`=1 and `cfg_ext_clk_i`=1, `core_rst_o` falls on the first clock edge after `por_pulse_i` falls.
- R5: Brown-out mode `cfg_bor_mode_i`: 2'b11 is always active, 2'b10 is active only while `sleep_i`=0, and 2'b0x is inactive. When it is inactive a low supply has no effect on `core_rst_o` or `cause_o`.
- R6: A brown-out trips only once `bor_low_i` has stayed high through BOR_QUAL_TICKS slow ticks. Shorter dips are ignored.
- R7: A brown-out trip puts the sequencer back in hold at any stage. After `bor_low_i` falls, the power-up count restarts from zero.
- R8: With `cfg_pin_en_i`=1, `ext_rst_ni` passes through a 2-flop synchronizer. It then counts as reset only after PIN_FILT_CYCLES consecutive low samples. Shorter low pulses leave `core_rst_o` at 0.
- R9: With `cfg_pin_en_i`=0, `ext_rst_ni` has no effect on `core_rst_o` or `cause_o`.
- R10: The timers run while the pin is held low. If the pin is released after they have expired, `core_rst_o` falls 3 clocks later, and no timer runs again.
- R11: `cause_o` becomes 2'b01 one clock after a brown-out trip. It becomes 2'b10 one clock after a filtered pin reset asserts. A power-on pulse takes priority over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| por_pulse_i | input | 1 | Power-on pulse, high while asserted |
| bor_low_i | input | 1 | Supply below brown-out level |
| slow_tick_i | input | 1 | One-cycle tick from the slow clock domain |
| sleep_i | input | 1 | Chip is in sleep |
| ext_rst_ni | input | 1 | External reset pin, active low |
| cfg_pwrt_dis_i | input | 1 | 1 skips the power-up delay |
| cfg_ext_clk_i | input | 1 | 1 skips the oscillator start-up delay |
| cfg_bor_mode_i | input | 2 | Brown-out mode |
| cfg_pin_en_i | input | 1 | 1 enables the external reset pin |
| core_rst_o | output | 1 | Chip reset, active high |
| cause_o | output | 2 | Last reset cause: 00 power-on, 01 brown-out, 10 pin |

## Verification
Some properties are checked on every cycle. A power-on pulse forces reset at the next clock. The power-up counter stays in range. A trip can only rise while the brown-out mode was active. A disabled pin never yields reset. A skipped start-up stage is never entered. A trip always moves the cause to brown-out.

Other properties are shown only by bench scenarios. These are the exact release cycle after a full tick count and start-up count, and the restart of the power-up count after a mid-count brown-out. They also include the 3-versus-4 cycle boundary of the pin filter, the qualification boundary of dips, and immediate release of a pin held past the timeouts.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD = 2'd0,
    SEQ_PWRT = 2'd1,
    SEQ_OST  = 2'd2,
    SEQ_RUN  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    CAUSE_POR = 2'b00,
    CAUSE_BOR = 2'b01,
    CAUSE_PIN = 2'b10
  } rst_cause_e;

  // 11: always, 10: awake only, 0x: off
  function automatic logic bor_active(input logic [1:0] mode, input logic sleep);
    return mode[1] & (mode[0] | ~sleep);
  endfunction

endpackage

// File: rtl/por_pin_filter.sv
module por_pin_filter #(
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic pin_en_i,
  output logic pin_rst_o
);

  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_LEN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   pin_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
  end

  assign pin_low = ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!pin_low)        cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign pin_rst_o = pin_en_i & (cnt_q == CNT_MAX);

  p_pin_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_en_i |-> !pin_rst_o);

  p_pin_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pin_rst_o) && $past(pin_en_i)) |-> $past(pin_low));

endmodule

// File: rtl/por_bor_qual.sv
module por_bor_qual
  import por_seq_pkg::*;
#(
  parameter int QUAL_TICKS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bor_low_i,
  input  logic       slow_tick_i,
  input  logic [1:0] mode_i,
  input  logic       sleep_i,
  output logic       trip_o
);

  localparam int CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(QUAL_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          trip_q;
  logic          en;

  assign en = bor_active(mode_i, sleep_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (!bor_low_i || !en) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (slow_tick_i && !trip_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) trip_q <= 1'b1;
    end
  end

  assign trip_o = trip_q;

  p_bor_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_o) |-> $past(bor_active(mode_i, sleep_i)));

  p_bor_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |-> $past(bor_low_i));

endmodule

// File: rtl/por_timer_seq.sv
module por_timer_seq
  import por_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 2048,
  parameter int OST_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic slow_tick_i,
  input  logic pwrt_en_i,
  input  logic ost_en_i,
  output logic released_o
);

  localparam int PW = $clog2(PWRT_TICKS + 1);
  localparam int OW = $clog2(OST_CYCLES + 1);
  localparam logic [PW-1:0] PW_LAST = PW'(PWRT_TICKS - 1);
  localparam logic [OW-1:0] OW_LAST = OW'(OST_CYCLES - 1);

  seq_state_e    state_q;
  logic [PW-1:0] pw_cnt_q;
  logic [OW-1:0] ost_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_HOLD;
      pw_cnt_q  <= '0;
      ost_cnt_q <= '0;
    end else if (hold_i) begin
      state_q   <= SEQ_HOLD;
      pw_cnt_q  <= '0;
      ost_cnt_q <= '0;
    end else begin
      unique case (state_q)
        SEQ_HOLD: begin
          pw_cnt_q  <= '0;
          ost_cnt_q <= '0;
          if (pwrt_en_i)     state_q <= SEQ_PWRT;
          else if (ost_en_i) state_q <= SEQ_OST;
          else               state_q <= SEQ_RUN;
        end
        SEQ_PWRT: begin
          if (slow_tick_i) begin
            if (pw_cnt_q == PW_LAST) begin
              pw_cnt_q <= '0;
              state_q  <= ost_en_i ? SEQ_OST : SEQ_RUN;
            end else begin
              pw_cnt_q <= pw_cnt_q + 1'b1;
            end
          end
        end
        SEQ_OST: begin
          if (ost_cnt_q == OW_LAST) begin
            ost_cnt_q <= '0;
            state_q   <= SEQ_RUN;
          end else begin
            ost_cnt_q <= ost_cnt_q + 1'b1;
          end
        end
        default: state_q <= SEQ_RUN;
      endcase
    end
  end

  assign released_o = (state_q == SEQ_RUN);

  p_pwrt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_PWRT) |-> (pw_cnt_q < PW'(PWRT_TICKS)));

  p_ost_skip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_PWRT && !ost_en_i) |=> (state_q != SEQ_OST));

  p_hold_back_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (state_q == SEQ_HOLD));

  p_pwrt_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_HOLD && !hold_i && pwrt_en_i) |=> (state_q == SEQ_PWRT));

endmodule

// File: rtl/por_seq_ctrl.sv
module por_seq_ctrl
  import por_seq_pkg::*;
#(
  parameter int PWRT_TICKS      = 2048,
  parameter int OST_CYCLES      = 1024,
  parameter int BOR_QUAL_TICKS  = 2,
  parameter int PIN_FILT_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_pulse_i,
  input  logic       bor_low_i,
  input  logic       slow_tick_i,
  input  logic       sleep_i,
  input  logic       ext_rst_ni,
  input  logic       cfg_pwrt_dis_i,
  input  logic       cfg_ext_clk_i,
  input  logic [1:0] cfg_bor_mode_i,
  input  logic       cfg_pin_en_i,
  output logic       core_rst_o,
  output logic [1:0] cause_o
);

  logic bor_trip, bor_trip_q;
  logic pin_rst, pin_rst_q;
  logic released;
  rst_cause_e cause_q;

  por_bor_qual #(.QUAL_TICKS(BOR_QUAL_TICKS)) i_bor_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bor_low_i  (bor_low_i),
    .slow_tick_i(slow_tick_i),
    .mode_i     (cfg_bor_mode_i),
    .sleep_i    (sleep_i),
    .trip_o     (bor_trip)
  );

  por_timer_seq #(.PWRT_TICKS(PWRT_TICKS), .OST_CYCLES(OST_CYCLES)) i_timer_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (por_pulse_i | bor_trip),
    .slow_tick_i(slow_tick_i),
    .pwrt_en_i  (~cfg_pwrt_dis_i),
    .ost_en_i   (~cfg_ext_clk_i),
    .released_o (released)
  );

  por_pin_filter #(.FILT_LEN(PIN_FILT_CYCLES), .SYNC_STAGES(2)) i_pin_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_ni   (ext_rst_ni),
    .pin_en_i (cfg_pin_en_i),
    .pin_rst_o(pin_rst)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q    <= CAUSE_POR;
      bor_trip_q <= 1'b0;
      pin_rst_q  <= 1'b0;
    end else begin
      bor_trip_q <= bor_trip;
      pin_rst_q  <= pin_rst;
      if (por_pulse_i)                 cause_q <= CAUSE_POR;
      else if (bor_trip && !bor_trip_q) cause_q <= CAUSE_BOR;
      else if (pin_rst && !pin_rst_q)   cause_q <= CAUSE_PIN;
    end
  end

  assign core_rst_o = ~released | pin_rst;
  assign cause_o    = cause_q;

  p_por_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_pulse_i |=> core_rst_o);

  p_cause_bor_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bor_trip) && !por_pulse_i) |=> (cause_o == CAUSE_BOR));

  p_trip_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bor_trip |=> core_rst_o);

endmodule

// File: tb/test_por_seq_ctrl.sv
`timescale 1ns/1ps
module test_por_seq_ctrl;

  localparam int P_PWRT = 12;
  localparam int P_OST  = 40;
  localparam int P_QUAL = 3;
  localparam int P_FILT = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic por_pulse_i = 1'b1;
  logic bor_low_i = 1'b0;
  logic slow_tick_i = 1'b0;
  logic sleep_i = 1'b0;
  logic ext_rst_ni = 1'b1;
  logic cfg_pwrt_dis_i = 1'b0;
  logic cfg_ext_clk_i = 1'b0;
  logic [1:0] cfg_bor_mode_i = 2'b00;
  logic cfg_pin_en_i = 1'b0;
  logic core_rst_o;
  logic [1:0] cause_o;

  int total = 0;
  int bad = 0;
  logic [1:0] exp_cause;

  always #2.5 clk = ~clk;

  por_seq_ctrl #(
    .PWRT_TICKS(P_PWRT), .OST_CYCLES(P_OST),
    .BOR_QUAL_TICKS(P_QUAL), .PIN_FILT_CYCLES(P_FILT)
  ) i_por_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .por_pulse_i(por_pulse_i), .bor_low_i(bor_low_i),
    .slow_tick_i(slow_tick_i), .sleep_i(sleep_i), .ext_rst_ni(ext_rst_ni),
    .cfg_pwrt_dis_i(cfg_pwrt_dis_i), .cfg_ext_clk_i(cfg_ext_clk_i),
    .cfg_bor_mode_i(cfg_bor_mode_i), .cfg_pin_en_i(cfg_pin_en_i),
    .core_rst_o(core_rst_o), .cause_o(cause_o)
  );

  function automatic logic exp_bor_trip(input logic [1:0] mode, input logic slp, input int k);
    return mode[1] && (mode[0] || !slp) && (k >= P_QUAL);
  endfunction

  function automatic logic exp_pin_hit(input int len);
    return len >= P_FILT;
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick_i = 1'b1;
      @(negedge clk);
      slow_tick_i = 1'b0;
    end
  endtask

  task automatic por_event();
    por_pulse_i = 1'b1;
    step(3);
    por_pulse_i = 1'b0;
    step(1);
  endtask

  task automatic pin_pulse(input int len, output logic seen);
    seen = 1'b0;
    ext_rst_ni = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      seen |= core_rst_o;
    end
    ext_rst_ni = 1'b1;
    for (int i = 0; i < P_FILT + 4; i++) begin
      @(negedge clk);
      seen |= core_rst_o;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic seen;
    void'($urandom(32'd4242));
    step(2);
    rst_ni = 1'b1;
    step(2);
    // R1 reset state
    chk("R1 rst during por", {1'b0, core_rst_o}, 2'd1);
    chk("R1 cause por", cause_o, 2'b00);

    // R2/R3 full chain
    por_pulse_i = 1'b0;
    step(1);
    ticks(P_PWRT - 1);
    chk("R2 pwrt not done", {1'b0, core_rst_o}, 2'd1);
    ticks(1);
    step(P_OST - 1);
    chk("R3 ost not done", {1'b0, core_rst_o}, 2'd1);
    step(1);
    chk("R3 released after ost", {1'b0, core_rst_o}, 2'd0);
    chk("R1 cause stays por", cause_o, 2'b00);

    // R1 por while running
    por_pulse_i = 1'b1;
    step(1);
    chk("R1 por reasserts", {1'b0, core_rst_o}, 2'd1);

    // R2 skip
    cfg_pwrt_dis_i = 1'b1;
    step(2);
    por_pulse_i = 1'b0;
    step(1);
    step(P_OST - 1);
    chk("R2 skip ost pending", {1'b0, core_rst_o}, 2'd1);
    step(1);
    chk("R2 skip pwrt release", {1'b0, core_rst_o}, 2'd0);

    // R4 no timeout
    cfg_ext_clk_i = 1'b1;
    por_pulse_i = 1'b1;
    step(2);
    por_pulse_i = 1'b0;
    step(1);
    chk("R4 immediate release", {1'b0, core_rst_o}, 2'd0);

    // R7 brown-out restarts power-up count
    cfg_pwrt_dis_i = 1'b0;
    cfg_bor_mode_i = 2'b11;
    por_event();
    ticks(5);
    bor_low_i = 1'b1;
    ticks(P_QUAL - 1);
    chk("R6 no trip yet", cause_o, 2'b00);
    ticks(1);
    step(1);
    chk("R11 cause bor", cause_o, 2'b01);
    chk("R7 held", {1'b0, core_rst_o}, 2'd1);
    bor_low_i = 1'b0;
    step(2);
    ticks(P_PWRT - 1);
    chk("R7 restarted count", {1'b0, core_rst_o}, 2'd1);
    ticks(1);
    chk("R7 release after full count", {1'b0, core_rst_o}, 2'd0);
    exp_cause = 2'b01;

    // R5/R6 random dips
    for (int it = 0; it < 16; it++) begin
      logic [1:0] mode;
      logic slp;
      logic exp_t;
      int k;
      mode = 2'($urandom_range(3, 0));
      slp  = 1'($urandom_range(1, 0));
      k    = $urandom_range(5, 1);
      if (it == 0) begin mode = 2'b10; slp = 1'b1; k = 5; end
      if (it == 1) begin mode = 2'b11; slp = 1'b1; k = P_QUAL - 1; end
      if (it == 2) begin mode = 2'b11; slp = 1'b0; k = P_QUAL; end
      exp_t = exp_bor_trip(mode, slp, k);
      cfg_bor_mode_i = mode;
      sleep_i = slp;
      bor_low_i = 1'b1;
      ticks(k);
      step(2);
      chk("R5 R6 dip reset", {1'b0, core_rst_o}, {1'b0, exp_t});
      if (exp_t) exp_cause = 2'b01;
      chk("R11 dip cause", cause_o, exp_cause);
      bor_low_i = 1'b0;
      sleep_i = 1'b0;
      step(2);
      ticks(P_PWRT);
      step(1);
      chk("R7 recovered", {1'b0, core_rst_o}, 2'd0);
    end
    cfg_bor_mode_i = 2'b00;

    // R8 pin filter boundary and random lengths
    cfg_pin_en_i = 1'b1;
    step(4);
    for (int it = 0; it < 14; it++) begin
      int len;
      len = $urandom_range(7, 1);
      if (it == 0) len = P_FILT - 1;
      if (it == 1) len = P_FILT;
      pin_pulse(len, seen);
      chk("R8 pin pulse", {1'b0, seen}, {1'b0, exp_pin_hit(len)});
      if (exp_pin_hit(len)) exp_cause = 2'b10;
      chk("R11 pin cause", cause_o, exp_cause);
      chk("R8 pin released", {1'b0, core_rst_o}, 2'd0);
    end

    // R9 pin disabled
    cfg_pin_en_i = 1'b0;
    exp_cause = cause_o;
    pin_pulse(10, seen);
    chk("R9 pin ignored", {1'b0, seen}, 2'd0);
    chk("R9 cause kept", cause_o, exp_cause);
    cfg_pin_en_i = 1'b1;
    step(2);

    // R10 pin held past timeouts
    cfg_ext_clk_i = 1'b0;
    ext_rst_ni = 1'b0;
    step(8);
    por_event();
    ticks(P_PWRT);
    step(P_OST + 2);
    chk("R10 pin holds reset", {1'b0, core_rst_o}, 2'd1);
    chk("R1 cause por over pin", cause_o, 2'b00);
    ext_rst_ni = 1'b1;
    step(2);
    chk("R10 before sync", {1'b0, core_rst_o}, 2'd1);
    step(1);
    chk("R10 immediate release", {1'b0, core_rst_o}, 2'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule